// File: doc/BRIEF.md
# Frame Transmit Retry Controller

This block sits on the host side of a serial storage link and supervises the sending of one frame at a time. A request arrives tagged as a data frame or a non-data frame. The controller launches it toward the link layer and then waits for the far end's verdict: a positive acknowledge or a reject. A non-data frame that is rejected is launched again, for as long as it takes, until it is accepted or software withdraws the port's run enable. A rejected data frame is never relaunched. The controller parks instead until software withdraws the run enable.

Every reject sets a sticky handshake diagnostic bit. A loss of physical-layer readiness sends the controller back to idle. If that loss happens while a frame is in flight, it also records an interface error flag. The flag is fatal for a data frame and non-fatal for a non-data frame. A loss while idle records nothing. A received task-file update that carries the device error bit, arriving while the matching interrupt enable is set, raises an interrupt and halts command processing. Clearing the run enable releases the halt. Framing, scrambling, CRC and the PHY are outside the block and appear only as handshake inputs.

Top module: `fis_tx_retry_ctrl`

## Requirements
- R1: After reset, no frame is launched, `done_ok`, `diag_h`, `if_fatal`, `if_nonfatal`, `halt_irq` and `retry_cnt` are 0, and `req_ready` is 1 while `run_en` and `phy_rdy` are 1.
- R2: A request taken while `req_ready` is 1 produces a one-cycle `tx_start` in the next cycle. When `rsp_ok` is then seen, the cycle after brings a one-cycle `done_ok` and `req_ready` back at 1.
- R3: When a non-data frame (`req_data`=0) is rejected (`rsp_err`), `tx_start` pulses again in the next cycle and `retry_cnt` rises by one. The counter is cleared when a new request is taken. When `RETRY_SAT`=1 it holds at its maximum value 2^RETRY_W-1.
- R4: A rejected data frame (`req_data`=1) is not launched again. `req_ready` stays 0 until `run_en` has been 0 for a cycle.
- R5: Each reject of a launched frame sets `diag_h`. The bit stays set until a cycle with `status_clr[0]`=1.
- R6: When `phy_rdy` falls during a launch, while waiting for a verdict, or while parked after a data reject, the controller returns to idle. Once `phy_rdy` returns, `req_ready` is 1.
- R7: A `phy_rdy` drop while a frame is in flight sets `if_fatal` for a data frame and `if_nonfatal` for a non-data frame. A drop while idle sets neither. `status_clr[2]` clears `if_fatal` and `status_clr[1]` clears `if_nonfatal`.
- R8: A cycle with `tf_update`, `tf_err` and `tf_err_ie` all at 1 raises `halt_irq` from the next cycle. While `halt_irq` is high, `req_ready` is 0 and no frame is launched. With `tf_err_ie`=0 no halt occurs.
- R9: `run_en`=0 returns the controller to idle in the next cycle and clears `halt_irq`. A verdict that arrives after this is ignored: it causes no launch and sets no `diag_h`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_en | input | 1 | Port run enable from software |
| phy_rdy | input | 1 | Physical layer ready |
| req_valid | input | 1 | Frame send request |
| req_data | input | 1 | 1 = data frame, 0 = non-data frame |
| req_ready | output | 1 | Controller idle and able to take a request |
| tx_start | output | 1 | One-cycle launch strobe to the link layer |
| rsp_ok | input | 1 | Far end accepted the frame |
| rsp_err | input | 1 | Far end rejected the frame |
| done_ok | output | 1 | One-cycle success pulse |
| retry_cnt | output | RETRY_W | Resends of the current non-data frame |
| tf_update | input | 1 | Received frame updates the task file |
| tf_err | input | 1 | Error bit of the received status |
| tf_err_ie | input | 1 | Task-file error interrupt enable |
| halt_irq | output | 1 | Task-file error interrupt, command processing halted |
| status_clr | input | 3 | Write-one-to-clear: [0] diag_h, [1] if_nonfatal, [2] if_fatal |
| diag_h | output | 1 | Sticky handshake-reject diagnostic |
| if_nonfatal | output | 1 | Sticky non-fatal interface error |
| if_fatal | output | 1 | Sticky fatal interface error |

## Verification
The bench rejects non-data frames many times in a row. This shows the counter saturating rather than wrapping, and shows that no launch is lost. A design that applied one retry policy to both frame types would either relaunch a data frame, which surfaces as an unexpected launch in the scoreboard, or abandon a non-data frame. PHY drops are placed while idle, in flight and while parked. A design that flagged every drop, or that stayed parked, would show a wrong interface flag or a `req_ready` stuck at 0. Verdicts arriving after the run enable has been withdrawn, and halts requested with the enable clear, check that stale or masked events cause no launch, no diagnostic and no halt.

// File: rtl/fistx_pkg.sv
package fistx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_WAIT_STATUS,
      ST_WAIT_STOP,
      ST_HALTED
   } tx_state_t;
endpackage

// File: rtl/fistx_retry_cnt.sv
module fistx_retry_cnt #(
   parameter int RETRY_W   = 8,
   parameter bit RETRY_SAT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               inc,
   output logic [RETRY_W-1:0] cnt
);
   localparam logic [RETRY_W-1:0] CNT_MAX = {RETRY_W{1'b1}};

   logic [RETRY_W-1:0] cnt_nxt;

   generate
      if (RETRY_W < 1) begin : g_bad_width
         $error("RETRY_W must be at least 1");
      end
      if (RETRY_SAT) begin : g_sat
         assign cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt_nxt;
   end

   // R3: the count only moves on a clear or a resend
   assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/fistx_fsm.sv
module fistx_fsm
   import fistx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run_en,
   input  logic      phy_rdy,
   input  logic      req_valid,
   input  logic      req_data,
   input  logic      rsp_ok,
   input  logic      rsp_err,
   input  logic      halt_evt,
   output tx_state_t state,
   output logic      cur_data,
   output logic      req_ready,
   output logic      tx_start,
   output logic      done_ok,
   output logic      cnt_clr,
   output logic      cnt_inc,
   output logic      reject_seen
);
   tx_state_t nxt;
   logic      live;
   logic      in_wait;
   logic      accept;

   assign live      = run_en && phy_rdy && !halt_evt;
   assign in_wait   = (state == ST_WAIT_STATUS);
   assign req_ready = (state == ST_IDLE) && run_en && phy_rdy;
   assign tx_start  = (state == ST_SEND);
   assign accept    = req_ready && !halt_evt && req_valid;
   assign cnt_clr   = accept;
   assign cnt_inc   = in_wait && live && !rsp_ok && rsp_err && !cur_data;
   assign reject_seen = in_wait && rsp_err && !rsp_ok;

   always_comb begin
      nxt = state;
      if (!run_en) begin
         nxt = ST_IDLE;
      end else if (halt_evt) begin
         nxt = ST_HALTED;
      end else begin
         unique case (state)
            ST_IDLE:        if (phy_rdy && req_valid) nxt = ST_SEND;
            ST_SEND:        nxt = phy_rdy ? ST_WAIT_STATUS : ST_IDLE;
            ST_WAIT_STATUS: begin
               if (!phy_rdy)     nxt = ST_IDLE;
               else if (rsp_ok)  nxt = ST_IDLE;
               else if (rsp_err) nxt = cur_data ? ST_WAIT_STOP : ST_SEND;
            end
            ST_WAIT_STOP:   if (!phy_rdy) nxt = ST_IDLE;
            ST_HALTED:      nxt = ST_HALTED;
            default:        nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_data <= 1'b0;
         done_ok  <= 1'b0;
      end else begin
         state   <= nxt;
         done_ok <= in_wait && live && rsp_ok;
         if (accept) cur_data <= req_data;
      end
   end

   // R2: a launch lasts exactly one cycle
   assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);
   // R4: parking only ever happens for a data frame
   assert_park_is_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_STOP) |-> cur_data);
   // R6: losing the PHY outside a halt leads back to idle
   assert_phy_drop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!phy_rdy && run_en && !halt_evt && state != ST_HALTED) |=> (state == ST_IDLE));
   // R8: nothing is taken or launched while halted
   assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALTED) |-> (!tx_start && !req_ready));
   // R9: withdrawing the run enable idles the controller
   assert_run_clear_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (state == ST_IDLE));
endmodule

// File: rtl/fistx_status.sv
module fistx_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_frame,
   input  logic       frame_data,
   input  logic       phy_rdy,
   input  logic       reject_seen,
   input  logic [2:0] status_clr,
   output logic       diag_h,
   output logic       if_nonfatal,
   output logic       if_fatal
);
   logic drop_in_frame;

   assign drop_in_frame = in_frame && !phy_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         diag_h      <= 1'b0;
         if_nonfatal <= 1'b0;
         if_fatal    <= 1'b0;
      end else begin
         if (reject_seen)                       diag_h <= 1'b1;
         else if (status_clr[0])                diag_h <= 1'b0;
         if (drop_in_frame && !frame_data)      if_nonfatal <= 1'b1;
         else if (status_clr[1])                if_nonfatal <= 1'b0;
         if (drop_in_frame && frame_data)       if_fatal <= 1'b1;
         else if (status_clr[2])                if_fatal <= 1'b0;
      end
   end

   // R5: the diagnostic bit holds until it is cleared
   assert_diag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_h && !status_clr[0]) |=> diag_h);
   // R7: a drop with no frame in flight leaves the interface flags alone
   assert_idle_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame && status_clr[2:1] == 2'b00) |=> ($stable(if_fatal) && $stable(if_nonfatal)));
endmodule

// File: rtl/fis_tx_retry_ctrl.sv
module fis_tx_retry_ctrl
   import fistx_pkg::*;
#(
   parameter int RETRY_W   = 8,
   parameter bit RETRY_SAT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic               phy_rdy,
   input  logic               req_valid,
   input  logic               req_data,
   output logic               req_ready,
   output logic               tx_start,
   input  logic               rsp_ok,
   input  logic               rsp_err,
   output logic               done_ok,
   output logic [RETRY_W-1:0] retry_cnt,
   input  logic               tf_update,
   input  logic               tf_err,
   input  logic               tf_err_ie,
   output logic               halt_irq,
   input  logic [2:0]         status_clr,
   output logic               diag_h,
   output logic               if_nonfatal,
   output logic               if_fatal
);
   tx_state_t state;
   logic      cur_data;
   logic      halt_evt;
   logic      cnt_clr;
   logic      cnt_inc;
   logic      reject_seen;
   logic      in_frame;

   assign halt_evt = tf_update && tf_err && tf_err_ie;
   assign halt_irq = (state == ST_HALTED);
   assign in_frame = (state == ST_SEND) || (state == ST_WAIT_STATUS);

   fistx_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .phy_rdy     (phy_rdy),
      .req_valid   (req_valid),
      .req_data    (req_data),
      .rsp_ok      (rsp_ok),
      .rsp_err     (rsp_err),
      .halt_evt    (halt_evt),
      .state       (state),
      .cur_data    (cur_data),
      .req_ready   (req_ready),
      .tx_start    (tx_start),
      .done_ok     (done_ok),
      .cnt_clr     (cnt_clr),
      .cnt_inc     (cnt_inc),
      .reject_seen (reject_seen)
   );

   fistx_retry_cnt #(
      .RETRY_W   (RETRY_W),
      .RETRY_SAT (RETRY_SAT)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (retry_cnt)
   );

   fistx_status u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_frame    (in_frame),
      .frame_data  (cur_data),
      .phy_rdy     (phy_rdy),
      .reject_seen (reject_seen),
      .status_clr  (status_clr),
      .diag_h      (diag_h),
      .if_nonfatal (if_nonfatal),
      .if_fatal    (if_fatal)
   );
endmodule

// File: tb/fis_tx_retry_ctrl_tb_top.sv
module fis_tx_retry_ctrl_tb_top;
   localparam int RW = 3;
   localparam int EV_START = 1;
   localparam int EV_DONE  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b1, phy_rdy = 1'b1;
   logic          req_valid = 1'b0, req_data = 1'b0;
   logic          rsp_ok = 1'b0, rsp_err = 1'b0;
   logic          tf_update = 1'b0, tf_err = 1'b0, tf_err_ie = 1'b0;
   logic [2:0]    status_clr = 3'b000;
   logic          req_ready, tx_start, done_ok, halt_irq;
   logic          diag_h, if_nonfatal, if_fatal;
   logic [RW-1:0] retry_cnt;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   bit finished = 1'b0;

   always #4 clk = ~clk;

   fis_tx_retry_ctrl #(.RETRY_W(RW), .RETRY_SAT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .phy_rdy(phy_rdy),
      .req_valid(req_valid), .req_data(req_data), .req_ready(req_ready),
      .tx_start(tx_start), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
      .done_ok(done_ok), .retry_cnt(retry_cnt), .tf_update(tf_update),
      .tf_err(tf_err), .tf_err_ie(tf_err_ie), .halt_irq(halt_irq),
      .status_clr(status_clr), .diag_h(diag_h), .if_nonfatal(if_nonfatal),
      .if_fatal(if_fatal)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // monitor: every launch and success pulse must match the next expected event
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (tx_start) begin
            if (exp_q.size() == 0) chk("R2/R4/R8 unexpected launch", EV_START, 0);
            else chk("R2/R3 launch order", EV_START, exp_q.pop_front());
         end
         if (done_ok) begin
            if (exp_q.size() == 0) chk("R2 unexpected done", EV_DONE, 0);
            else chk("R2 done order", EV_DONE, exp_q.pop_front());
         end
      end
   end

   task automatic issue(input logic d);
      req_valid = 1'b1; req_data = d;
      exp_q.push_back(EV_START);
      tick();
      req_valid = 1'b0;
      tick();
   endtask

   task automatic reply_ok();
      rsp_ok = 1'b1;
      exp_q.push_back(EV_DONE);
      tick();
      rsp_ok = 1'b0;
   endtask

   task automatic reject_nd();
      rsp_err = 1'b1;
      exp_q.push_back(EV_START);
      tick();
      rsp_err = 1'b0;
      tick();
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready", int'(req_ready), 1);
      chk("R1 diag_h", int'(diag_h), 0);
      chk("R1 halt", int'(halt_irq), 0);
      chk("R1 retry_cnt", int'(retry_cnt), 0);
      chk("R1 flags", int'({if_fatal, if_nonfatal}), 0);

      // R2: plain success
      issue(1'b0);
      chk("R2 busy while waiting", int'(req_ready), 0);
      reply_ok();
      @(negedge clk);
      chk("R2 ready after done", int'(req_ready), 1);
      chk("R2 no retries", int'(retry_cnt), 0);

      // R3: two rejects of a non-data frame, then success
      issue(1'b0);
      reject_nd();
      reject_nd();
      @(negedge clk);
      chk("R3 retry_cnt after two", int'(retry_cnt), 2);
      chk("R5 diag_h on reject", int'(diag_h), 1);
      reply_ok();
      repeat (3) tick();
      @(negedge clk);
      chk("R5 diag_h sticky", int'(diag_h), 1);
      status_clr = 3'b001; tick(); status_clr = 3'b000;
      @(negedge clk);
      chk("R5 diag_h cleared", int'(diag_h), 0);

      // R3: saturation at 7 after nine rejects, cleared on next accept
      issue(1'b0);
      for (int i = 0; i < 9; i++) reject_nd();
      @(negedge clk);
      chk("R3 saturated", int'(retry_cnt), 7);
      reply_ok();
      issue(1'b0);
      @(negedge clk);
      chk("R3 cleared on accept", int'(retry_cnt), 0);
      reply_ok();

      // R4: data frame reject parks until run_en drops
      status_clr = 3'b001; tick(); status_clr = 3'b000;
      issue(1'b1);
      rsp_err = 1'b1; tick(); rsp_err = 1'b0;
      repeat (5) tick();
      @(negedge clk);
      chk("R4 parked not ready", int'(req_ready), 0);
      chk("R5 diag_h on data reject", int'(diag_h), 1);
      run_en = 1'b0; tick(); run_en = 1'b1; tick();
      @(negedge clk);
      chk("R4 ready after stop", int'(req_ready), 1);

      // R6: drop while parked returns to idle
      issue(1'b1);
      rsp_err = 1'b1; tick(); rsp_err = 1'b0;
      phy_rdy = 1'b0; tick(); phy_rdy = 1'b1;
      @(negedge clk);
      chk("R6 idle after parked drop", int'(req_ready), 1);
      chk("R7 parked drop no fatal", int'(if_fatal), 0);

      // R6/R7: in-flight drops
      issue(1'b0);
      phy_rdy = 1'b0; tick(); phy_rdy = 1'b1;
      @(negedge clk);
      chk("R6 idle after wait drop", int'(req_ready), 1);
      chk("R7 nonfatal set", int'(if_nonfatal), 1);
      chk("R7 fatal clear", int'(if_fatal), 0);
      issue(1'b1);
      phy_rdy = 1'b0; tick(); phy_rdy = 1'b1;
      @(negedge clk);
      chk("R7 fatal set", int'(if_fatal), 1);
      status_clr = 3'b110; tick(); status_clr = 3'b000;
      @(negedge clk);
      chk("R7 flags cleared", int'({if_fatal, if_nonfatal}), 0);
      phy_rdy = 1'b0; repeat (3) tick(); phy_rdy = 1'b1; tick();
      @(negedge clk);
      chk("R7 idle drop no flags", int'({if_fatal, if_nonfatal}), 0);
      chk("R6 ready after idle drop", int'(req_ready), 1);

      // R8: masked error does not halt
      tf_update = 1'b1; tf_err = 1'b1; tf_err_ie = 1'b0; tick();
      tf_update = 1'b0;
      @(negedge clk);
      chk("R8 masked no halt", int'(halt_irq), 0);
      chk("R8 masked still ready", int'(req_ready), 1);
      tf_update = 1'b1; tf_err_ie = 1'b1; tick();
      tf_update = 1'b0; tf_err = 1'b0;
      @(negedge clk);
      chk("R8 halt raised", int'(halt_irq), 1);
      chk("R8 halted not ready", int'(req_ready), 0);
      req_valid = 1'b1; repeat (4) tick(); req_valid = 1'b0;
      @(negedge clk);
      chk("R8 still halted", int'(halt_irq), 1);
      run_en = 1'b0; tick();
      @(negedge clk);
      chk("R9 halt cleared", int'(halt_irq), 0);
      run_en = 1'b1; tick();

      // R9: verdict after run enable withdrawn is ignored
      status_clr = 3'b001; tick(); status_clr = 3'b000;
      issue(1'b0);
      run_en = 1'b0; tick(); run_en = 1'b1;
      rsp_err = 1'b1; tick(); rsp_err = 1'b0;
      repeat (2) tick();
      @(negedge clk);
      chk("R9 stale reject no diag", int'(diag_h), 0);
      chk("R9 idle ready", int'(req_ready), 1);

      repeat (2) tick();
      chk("R2 scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule